// File: doc/BRIEF.md
# Scan Bypass and User Data Register Port

This block sits next to a boundary scan chain and picks which data register the test port talks to. It decodes the current instruction value and asserts one of two user select strobes, or falls back to the boundary chain or the one-bit bypass flop. It then steers the serial output to the matching source. Fabric logic that builds its own test registers gets a gated data-register clock and an active-low idle indication from this block. The controller state machine is outside it and supplies one-hot state indications.

Instruction codes are parameters, except that all-ones is fixed as the bypass code. Two codes select the boundary chain, one for external test and one for sampling, and two codes select the user registers. Every other value is treated as bypass.

Top module: `tapdr_port`

## Requirements
- R1: When the bypass register is selected and the state is Capture-DR, the bypass flop loads 0 at the rising TCK edge.
- R2: When the bypass register is selected and the state is Shift-DR, the bypass flop takes TDI at each rising TCK edge, so a bit reaches TDO one TCK later.
- R3: The user-1 code (default 3'b010) drives `usr1_sel` high and the user-2 code (default 3'b011) drives `usr2_sel` high. At most one select is high at any time.
- R4: The all-ones code (3'b111), and any code that is none of the four named codes (3'b100, 3'b101, 3'b110 by default), selects the bypass register and leaves both user selects low.
- R5: In Shift-DR with a user instruction active, TDO carries that instruction's user serial input.
- R6: In Shift-DR with the external-test code (3'b000) or the sample code (3'b001), TDO carries the boundary chain serial output.
- R7: In Shift-IR, TDO carries the instruction register serial output, whatever code is held.
- R8: In any state other than Shift-IR or Shift-DR, `tdo_oe` is low and `tdo` is 0.
- R9: `dr_clk` is high only during the high phase of TCK, and only when Capture-DR or Shift-DR held with a user instruction active at the preceding falling TCK edge. Otherwise it stays low.
- R10: `idle_n` is the NAND of TCK and the Run-Test/Idle indication.
- R11: A low `trst_n` clears the bypass flop and the clock-gate enable at once, without waiting for a TCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| ir_code | input | IR_W | Current instruction register value |
| st_capture_dr | input | 1 | Controller is in Capture-DR |
| st_shift_dr | input | 1 | Controller is in Shift-DR |
| st_shift_ir | input | 1 | Controller is in Shift-IR |
| st_run_idle | input | 1 | Controller is in Run-Test/Idle |
| ir_so | input | 1 | Instruction register serial output |
| chain_so | input | 1 | Boundary chain serial output |
| usr1_so | input | 1 | Serial return data from user register 1 |
| usr2_so | input | 1 | Serial return data from user register 2 |
| usr1_sel | output | 1 | User instruction 1 active |
| usr2_sel | output | 1 | User instruction 2 active |
| dr_clk | output | 1 | Gated data-register clock for user logic |
| idle_n | output | 1 | NAND of TCK and Run-Test/Idle |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for TDO |

## Verification
The bench walks every instruction code, including the unused ones. A decoder that missed the fallback would let the boundary chain or a stale user input drive TDO where the bypass bit belongs. A directed sequence fills the bypass flop with ones and then passes through Capture-DR, which shows whether the capture load of 0 was dropped. The gated clock is sampled in both TCK phases and after instruction changes: a design that gated with the live enable instead of the one taken at the falling edge would pulse in the wrong cycle, and one that gated on any state would clock user logic during Shift-IR. A reset pulled in the middle of a high phase shows whether the bypass flop and clock enable clear asynchronously.

// File: rtl/tapdr_pkg.sv
`timescale 1ns/100ps
package tapdr_pkg;
   typedef enum logic [1:0] {
      DR_CHAIN  = 2'd0,
      DR_BYPASS = 2'd1,
      DR_USER1  = 2'd2,
      DR_USER2  = 2'd3
   } dr_sel_e;

   localparam int unsigned NUM_USER = 2;
endpackage

// File: rtl/tapdr_decode.sv
`timescale 1ns/100ps
module tapdr_decode
   import tapdr_pkg::*;
#(
   parameter int unsigned     IR_W        = 3,
   parameter logic [IR_W-1:0] EXTEST_CODE = 'd0,
   parameter logic [IR_W-1:0] SAMPLE_CODE = 'd1,
   parameter logic [IR_W-1:0] USER1_CODE  = 'd2,
   parameter logic [IR_W-1:0] USER2_CODE  = 'd3
) (
   input  logic [IR_W-1:0]     ir_code,
   output logic [NUM_USER-1:0] usr_hit,
   output dr_sel_e             dr_sel
);
   logic chain_hit;

   for (genvar u = 0; u < NUM_USER; u++) begin : g_user
      localparam logic [IR_W-1:0] CODE = (u == 0) ? USER1_CODE : USER2_CODE;
      assign usr_hit[u] = (ir_code == CODE);
   end

   assign chain_hit = (ir_code == EXTEST_CODE) || (ir_code == SAMPLE_CODE);

   always_comb begin
      if (usr_hit[0])      dr_sel = DR_USER1;
      else if (usr_hit[1]) dr_sel = DR_USER2;
      else if (chain_hit)  dr_sel = DR_CHAIN;
      else                 dr_sel = DR_BYPASS;
   end
endmodule

// File: rtl/tapdr_bypass.sv
`timescale 1ns/100ps
module tapdr_bypass (
   input  logic tck,
   input  logic trst_n,
   input  logic tdi,
   input  logic active,
   input  logic capture,
   input  logic shift,
   output logic byp_q
);
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)               byp_q <= 1'b0;
      else if (active && capture) byp_q <= 1'b0;
      else if (active && shift)   byp_q <= tdi;
   end
endmodule

// File: rtl/tapdr_clkgate.sv
`timescale 1ns/100ps
module tapdr_clkgate (
   input  logic tck,
   input  logic trst_n,
   input  logic enable,
   output logic gclk
);
   logic en_q;

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) en_q <= 1'b0;
      else         en_q <= enable;
   end

   assign gclk = tck & en_q;
endmodule

// File: rtl/tapdr_port.sv
`timescale 1ns/100ps
module tapdr_port
   import tapdr_pkg::*;
#(
   parameter int unsigned     IR_W        = 3,
   parameter logic [IR_W-1:0] EXTEST_CODE = 'd0,
   parameter logic [IR_W-1:0] SAMPLE_CODE = 'd1,
   parameter logic [IR_W-1:0] USER1_CODE  = 'd2,
   parameter logic [IR_W-1:0] USER2_CODE  = 'd3
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  logic [IR_W-1:0] ir_code,
   input  logic            st_capture_dr,
   input  logic            st_shift_dr,
   input  logic            st_shift_ir,
   input  logic            st_run_idle,
   input  logic            ir_so,
   input  logic            chain_so,
   input  logic            usr1_so,
   input  logic            usr2_so,
   output logic            usr1_sel,
   output logic            usr2_sel,
   output logic            dr_clk,
   output logic            idle_n,
   output logic            tdo,
   output logic            tdo_oe
);
   localparam logic [IR_W-1:0] BYPASS_CODE = '1;

   if (IR_W < 2) begin : g_err_width
      $error("tapdr_port: IR_W must be at least 2");
   end
   if (EXTEST_CODE == BYPASS_CODE || SAMPLE_CODE == BYPASS_CODE ||
       USER1_CODE == BYPASS_CODE || USER2_CODE == BYPASS_CODE) begin : g_err_ones
      $error("tapdr_port: all-ones is reserved for bypass");
   end
   if (USER1_CODE == USER2_CODE || USER1_CODE == EXTEST_CODE ||
       USER1_CODE == SAMPLE_CODE || USER2_CODE == EXTEST_CODE ||
       USER2_CODE == SAMPLE_CODE) begin : g_err_dup
      $error("tapdr_port: instruction codes must be distinct");
   end

   logic [NUM_USER-1:0] usr_hit;
   dr_sel_e             dr_sel;
   logic                byp_q;
   logic                dr_src;
   logic                gate_en;

   tapdr_decode #(
      .IR_W(IR_W), .EXTEST_CODE(EXTEST_CODE), .SAMPLE_CODE(SAMPLE_CODE),
      .USER1_CODE(USER1_CODE), .USER2_CODE(USER2_CODE)
   ) u_decode (
      .ir_code (ir_code),
      .usr_hit (usr_hit),
      .dr_sel  (dr_sel)
   );

   tapdr_bypass u_bypass (
      .tck     (tck),
      .trst_n  (trst_n),
      .tdi     (tdi),
      .active  (dr_sel == DR_BYPASS),
      .capture (st_capture_dr),
      .shift   (st_shift_dr),
      .byp_q   (byp_q)
   );

   assign gate_en = (st_capture_dr || st_shift_dr) && (|usr_hit);

   tapdr_clkgate u_gate (
      .tck    (tck),
      .trst_n (trst_n),
      .enable (gate_en),
      .gclk   (dr_clk)
   );

   always_comb begin
      unique case (dr_sel)
         DR_USER1:  dr_src = usr1_so;
         DR_USER2:  dr_src = usr2_so;
         DR_CHAIN:  dr_src = chain_so;
         default:   dr_src = byp_q;
      endcase
   end

   assign tdo_oe   = st_shift_ir || st_shift_dr;
   assign tdo      = st_shift_ir ? ir_so : (st_shift_dr ? dr_src : 1'b0);
   assign usr1_sel = usr_hit[0];
   assign usr2_sel = usr_hit[1];
   assign idle_n   = ~(tck & st_run_idle);
endmodule

// File: rtl/tapdr_checker.sv
`timescale 1ns/100ps
module tapdr_checker #(
   parameter int unsigned IR_W = 3
) (
   input logic            tck,
   input logic            trst_n,
   input logic            tdi,
   input logic [IR_W-1:0] ir_code,
   input logic            st_capture_dr,
   input logic            st_shift_dr,
   input logic            st_shift_ir,
   input logic            usr1_sel,
   input logic            usr2_sel,
   input logic            dr_clk,
   input logic            idle_n,
   input logic            tdo_oe,
   input logic            byp_q
);
   AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
      (st_capture_dr && ir_code == '1) |=> !byp_q);                        // R1
   AST_BYP_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
      (st_shift_dr && !st_capture_dr && ir_code == '1) |=> byp_q == $past(tdi)); // R2
   AST_SEL_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({usr1_sel, usr2_sel}));                                     // R3
   AST_OE_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      !(st_shift_ir || st_shift_dr) |-> !tdo_oe);                          // R8
   AST_DRCLK_LOWPHASE: assert property (@(posedge tck) disable iff (!trst_n)
      !dr_clk);                                                            // R9
   AST_IDLE_LOWPHASE: assert property (@(posedge tck) disable iff (!trst_n)
      idle_n);                                                             // R10
endmodule

bind tapdr_port tapdr_checker #(.IR_W(IR_W)) u_chk (.*);

// File: tb/tapdr_port_bench.sv
`timescale 1ns/100ps
module tapdr_port_bench;
   localparam int IR_W = 3;

   logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
   logic [IR_W-1:0] ir_code = '1;
   logic st_capture_dr = 0, st_shift_dr = 0, st_shift_ir = 0, st_run_idle = 0;
   logic ir_so = 0, chain_so = 0, usr1_so = 0, usr2_so = 0;
   logic usr1_sel, usr2_sel, dr_clk, idle_n, tdo, tdo_oe;

   int n_cmp = 0, n_bad = 0;
   logic m_byp, m_en;

   tapdr_port u_tapdr_port (.*);

   always #2 tck = ~tck;

   // 0 chain, 1 bypass, 2 user1, 3 user2
   function automatic int dec_f(input logic [IR_W-1:0] c);
      case (c)
         3'd0, 3'd1: return 0;
         3'd2:       return 2;
         3'd3:       return 3;
         default:    return 1;
      endcase
   endfunction

   function automatic logic exp_tdo_f();
      if (st_shift_ir) return ir_so;
      if (!st_shift_dr) return 1'b0;
      case (dec_f(ir_code))
         0: return chain_so;
         2: return usr1_so;
         3: return usr2_so;
         default: return m_byp;
      endcase
   endfunction

   function automatic string tdo_req_f();
      if (st_shift_ir) return "R7";
      if (!st_shift_dr) return "R8";
      case (dec_f(ir_code))
         0: return "R6";
         2, 3: return "R5";
         default: return (ir_code == '1) ? "R2" : "R4";
      endcase
   endfunction

   always @(posedge tck or negedge trst_n) begin
      if (!trst_n) m_byp <= 1'b0;
      else if (dec_f(ir_code) == 1) begin
         if (st_capture_dr)    m_byp <= 1'b0;
         else if (st_shift_dr) m_byp <= tdi;
      end
   end

   always @(negedge tck or negedge trst_n) begin
      if (!trst_n) m_en <= 1'b0;
      else m_en <= (st_capture_dr || st_shift_dr) && (dec_f(ir_code) >= 2);
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b (ir=%0d t=%0t)", req, act, exp, ir_code, $time);
      end
   endtask

   task automatic check_high();
      check("R3", usr1_sel, dec_f(ir_code) == 2);
      check("R3", usr2_sel, dec_f(ir_code) == 3);
      check(tdo_req_f(), tdo, exp_tdo_f());
      check("R8", tdo_oe, st_shift_ir || st_shift_dr);
      check("R9", dr_clk, m_en);
      check("R10", idle_n, !st_run_idle);
   endtask

   task automatic check_low();
      check("R9", dr_clk, 1'b0);
      check("R10", idle_n, 1'b1);
   endtask

   // st: 0 none, 1 capture-dr, 2 shift-dr, 3 shift-ir, 4 run-idle
   task automatic drive(input logic [IR_W-1:0] c, input int st, input logic d);
      ir_code = c; tdi = d;
      st_capture_dr = (st == 1); st_shift_dr = (st == 2);
      st_shift_ir = (st == 3); st_run_idle = (st == 4);
   endtask

   task automatic step(input logic [IR_W-1:0] c, input int st, input logic d);
      @(posedge tck); #1;
      check_high();
      drive(c, st, d);
      {ir_so, chain_so, usr1_so, usr2_so} = 4'($urandom);
      @(negedge tck); #1;
      check_low();
      check_high_mid();
   endtask

   task automatic check_high_mid();
      check("R3", usr1_sel, dec_f(ir_code) == 2);
      check(tdo_req_f(), tdo, exp_tdo_f());
   endtask

   initial begin : watchdog
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd5417));
      drive('1, 2, 1'b1);
      #5;
      check("R11", tdo, 1'b0);
      check("R11", dr_clk, 1'b0);
      check("R3", usr1_sel | usr2_sel, 1'b0);
      @(negedge tck); trst_n = 1'b1;

      // R2: ones walk through the bypass flop
      for (int i = 0; i < 4; i++) step('1, 2, 1'b1);
      check("R2", tdo, 1'b1);
      // R1: capture clears the flop, then shift shows 0
      step('1, 1, 1'b1);
      step('1, 2, 1'b1);
      check("R1", tdo, 1'b0);
      // R4: unused codes behave as bypass
      step(3'd5, 2, 1'b1);
      step(3'd6, 2, 1'b0);
      check("R4", tdo, 1'b1);
      // R9: user shift pulses dr_clk, Shift-IR does not
      step(3'd2, 2, 1'b0);
      step(3'd2, 3, 1'b0);
      step(3'd3, 1, 1'b0);
      step(3'd0, 0, 1'b0);

      // R11: asynchronous clear in the high phase
      step('1, 2, 1'b1);
      step(3'd2, 2, 1'b1);
      @(posedge tck); #1;
      check("R9", dr_clk, 1'b1);
      check("R9", m_en, 1'b1);
      drive('1, 2, 1'b1);
      #0.5;
      check("R2", tdo, 1'b1);
      trst_n = 1'b0;
      #0.5;
      check("R11", dr_clk, 1'b0);
      check("R11", tdo, 1'b0);
      @(negedge tck); #1;
      trst_n = 1'b1;

      for (int i = 0; i < 3000; i++)
         step(IR_W'($urandom_range(0, 7)), int'($urandom_range(0, 4)), 1'($urandom));

      @(posedge tck); #1;
      check_high();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule